// File: doc/BRIEF.md
# Paged Data EEPROM Write Controller

This block fronts a small page of non-volatile data memory and contains a behavioural model of the storage cells. Software uses two ports. The data port covers a 64-byte window. It has an address, write data, a read strobe, a write strobe and read data with no wait state. The register port gives access to one byte-wide control register. The block does the programming in two ways. Single-byte programming starts as soon as a byte is written. Row programming first collects up to eight bytes of one aligned row and then commits all of them in one cycle.

A programming cycle lasts a fixed number of clock cycles, set by a parameter. For that whole time the block hides the cells and refuses changes to its control state. In row mode, the first data write after arming fixes the row. Any later access that falls outside that row is dropped and reported on an error pulse. Only the bytes that were actually written while armed change when the row is committed. Every other byte of the row keeps its old value.

Top module: `eerow_ctrl`

## Requirements
- R1: After reset the control register reads 00h, the busy bit is clear, and every cell reads the erased value FFh.
- R2: Control register fields are: bit 6 standby, bit 3 row start, bit 2 row mode, bit 1 busy (read-only), bit 0 programming enable. Bits 7, 5 and 4 always read 0, whatever value is written to them.
- R3: While standby is set, data reads return 00h, and data writes change no cell and start no cycle.
- R4: A data write while programming enable is 0 and row mode is 0 starts no cycle and leaves the cells unchanged.
- R5: In byte mode, a data write with enable set stores that byte. Busy reads 1 from the clock edge that samples the write, for exactly PROG_CYCLES cycles. Data reads return 00h during that time.
- R6: While row mode is set, the first data write fixes the row to address bits [5:3]. A later data read or write to another row is ignored, reads 00h, and pulses row_err on the next cycle.
- R7: The row start bit is accepted only if enable and row mode are already set and the same write keeps both set. In any other case start reads back 0 and no cycle begins.
- R8: A row commit updates exactly the bytes of the fixed row that were written after arming, at position address bits [2:0]. All other cells stay unchanged.
- R9: At the end of a row cycle, row mode and row start read 0. If software clears row mode before starting, the collected bytes are discarded and programmed nowhere.
- R10: While busy, control register writes are ignored and the register reads exactly 02h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_addr | input | ADDR_W | Byte address in the page window |
| mem_wdata | input | DATA_W | Data write value |
| mem_we | input | 1 | Data write strobe |
| mem_re | input | 1 | Data read strobe |
| mem_rdata | output | DATA_W | Data read value, same cycle |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register read value |
| row_err | output | 1 | One-cycle pulse after an off-row access in row mode |

## Verification
The bench uses the default 64-byte page with 8-byte rows and a programming length of 5 cycles. With these values, every cell can be programmed through byte mode and read back. Every row can be committed with its own partial byte mask, with the whole page compared after each commit. Because the cycle is short, each busy window can be counted exactly and a control write can be placed inside it. Expected cell contents come from an arithmetic data pattern held in a model array in the bench.

// File: rtl/eerow_pkg.sv
package eerow_pkg;
   localparam int CTL_STBY   = 6;
   localparam int CTL_START  = 3;
   localparam int CTL_RMODE  = 2;
   localparam int CTL_BUSY   = 1;
   localparam int CTL_EN     = 0;

   typedef struct packed {
      logic stby;
      logic en;
      logic rmode;
      logic start;
      logic busy;
   } ctl_state_t;
endpackage

// File: rtl/eerow_ctl.sv
module eerow_ctl
   import eerow_pkg::*;
#(
   parameter int PROG_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic [7:0] reg_wdata,
   input  logic       byte_trig,
   output ctl_state_t st,
   output logic       arm,
   output logic       drop,
   output logic       commit,
   output logic [7:0] reg_rdata
);
   localparam int CNT_W = $clog2(PROG_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

   logic             stby_q, en_q, rmode_q, start_q, busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic             wr_ok, start_ok, launch;

   assign wr_ok    = reg_we && !busy_q;
   assign start_ok = wr_ok && reg_wdata[CTL_START] && en_q && rmode_q
                     && reg_wdata[CTL_RMODE] && reg_wdata[CTL_EN];
   assign arm      = wr_ok && reg_wdata[CTL_RMODE] && !rmode_q;
   assign drop     = wr_ok && !reg_wdata[CTL_RMODE] && rmode_q;
   assign commit   = busy_q && (cnt_q == '0);
   assign launch   = start_ok || byte_trig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stby_q  <= 1'b0;
         en_q    <= 1'b0;
         rmode_q <= 1'b0;
         start_q <= 1'b0;
         busy_q  <= 1'b0;
         cnt_q   <= '0;
      end else begin
         if (commit) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            rmode_q <= 1'b0;
         end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
         end
         if (wr_ok) begin
            stby_q  <= reg_wdata[CTL_STBY];
            en_q    <= reg_wdata[CTL_EN];
            rmode_q <= reg_wdata[CTL_RMODE];
            start_q <= start_ok;
         end
         if (launch) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_LAST;
         end
      end
   end

   assign st = '{stby: stby_q, en: en_q, rmode: rmode_q, start: start_q, busy: busy_q};

   always_comb begin
      reg_rdata = 8'h00;
      if (busy_q) begin
         reg_rdata[CTL_BUSY] = 1'b1;
      end else begin
         reg_rdata[CTL_STBY]  = stby_q;
         reg_rdata[CTL_START] = start_q;
         reg_rdata[CTL_RMODE] = rmode_q;
         reg_rdata[CTL_EN]    = en_q;
      end
   end
endmodule

// File: rtl/eerow_row_latch.sv
module eerow_row_latch #(
   parameter int ADDR_W = 6,
   parameter int SEL_W  = 3,
   parameter int DATA_W = 8,
   localparam int ROW_W = ADDR_W - SEL_W,
   localparam int ROWB  = 1 << SEL_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   ld,
   input  logic [ADDR_W-1:0]      ld_addr,
   input  logic [DATA_W-1:0]      ld_data,
   output logic [ROW_W-1:0]       row_q,
   output logic                   row_valid,
   output logic [ROWB-1:0]        mask_q,
   output logic [ROWB*DATA_W-1:0] data_q
);
   logic [SEL_W-1:0] sel;
   assign sel = ld_addr[SEL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q     <= '0;
         row_valid <= 1'b0;
      end else begin
         if (clr) row_valid <= 1'b0;
         if (ld && (clr || !row_valid)) begin
            row_q     <= ld_addr[ADDR_W-1:SEL_W];
            row_valid <= 1'b1;
         end
      end
   end

   for (genvar g = 0; g < ROWB; g++) begin : g_slot
      localparam logic [SEL_W-1:0] SLOT = SEL_W'(g);
      logic hit;
      assign hit = ld && (sel == SLOT);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[g]                    <= 1'b0;
            data_q[g*DATA_W +: DATA_W]   <= '0;
         end else if (hit) begin
            mask_q[g]                    <= 1'b1;
            data_q[g*DATA_W +: DATA_W]   <= ld_data;
         end else if (clr) begin
            mask_q[g]                    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/eerow_cells.sv
module eerow_cells #(
   parameter int               ADDR_W      = 6,
   parameter int               SEL_W       = 3,
   parameter int               DATA_W      = 8,
   parameter logic [DATA_W-1:0] ERASED     = '1,
   parameter bit               RESET_CELLS = 1'b1,
   localparam int ROW_W = ADDR_W - SEL_W,
   localparam int ROWB  = 1 << SEL_W,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   commit,
   input  logic [ROW_W-1:0]       row,
   input  logic [ROWB-1:0]        mask,
   input  logic [ROWB*DATA_W-1:0] data,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [DATA_W-1:0]      rd_data
);
   logic [DATA_W-1:0] cell_q [DEPTH];

   for (genvar c = 0; c < DEPTH; c++) begin : g_cell
      localparam logic [ROW_W-1:0] CROW = ROW_W'(c >> SEL_W);
      localparam int               CSEL = c % ROWB;
      logic              we;
      logic [DATA_W-1:0] q;
      assign we = commit && (row == CROW) && mask[CSEL];
      if (RESET_CELLS) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= ERASED;
            else if (we) q <= data[CSEL*DATA_W +: DATA_W];
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we) q <= data[CSEL*DATA_W +: DATA_W];
         end
      end
      assign cell_q[c] = q;
   end

   assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/eerow_ctrl.sv
module eerow_ctrl
   import eerow_pkg::*;
#(
   parameter int                ADDR_W      = 6,
   parameter int                DATA_W      = 8,
   parameter int                SEL_W       = 3,
   parameter int                PROG_CYCLES = 16,
   parameter logic [DATA_W-1:0] ERASED      = '1,
   parameter bit                RESET_CELLS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_we,
   input  logic              mem_re,
   output logic [DATA_W-1:0] mem_rdata,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              row_err
);
   localparam int ROW_W = ADDR_W - SEL_W;
   localparam int ROWB  = 1 << SEL_W;

   if (PROG_CYCLES < 2) begin : g_bad_cycles
      $error("PROG_CYCLES must be at least 2");
   end
   if (SEL_W < 1 || SEL_W >= ADDR_W) begin : g_bad_sel
      $error("SEL_W must lie between 1 and ADDR_W-1");
   end
   if (ADDR_W > 10) begin : g_bad_addr
      $error("ADDR_W too large for a behavioural page");
   end

   ctl_state_t              st;
   logic                    arm, drop, commit;
   logic                    byte_trig, row_ld, ld, clr;
   logic                    mem_ok, off_row;
   logic [ROW_W-1:0]        row_q;
   logic                    row_valid;
   logic [ROWB-1:0]         mask_q;
   logic [ROWB*DATA_W-1:0]  data_q;
   logic [DATA_W-1:0]       cell_rd;
   logic                    busy_w, stby_w, rmode_w, start_w, en_w;

   assign mem_ok    = !st.busy && !st.stby;
   assign off_row   = st.rmode && row_valid && (mem_addr[ADDR_W-1:SEL_W] != row_q);
   assign byte_trig = mem_we && mem_ok && !st.rmode && st.en;
   assign row_ld    = mem_we && mem_ok && st.rmode && !off_row;
   assign ld        = byte_trig || row_ld;
   assign clr       = arm || drop || commit || byte_trig;

   eerow_ctl #(.PROG_CYCLES(PROG_CYCLES)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .byte_trig (byte_trig),
      .st        (st),
      .arm       (arm),
      .drop      (drop),
      .commit    (commit),
      .reg_rdata (reg_rdata)
   );

   eerow_row_latch #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .ld        (ld),
      .ld_addr   (mem_addr),
      .ld_data   (mem_wdata),
      .row_q     (row_q),
      .row_valid (row_valid),
      .mask_q    (mask_q),
      .data_q    (data_q)
   );

   eerow_cells #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W), .DATA_W(DATA_W),
      .ERASED(ERASED), .RESET_CELLS(RESET_CELLS)
   ) u_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (commit),
      .row     (row_q),
      .mask    (mask_q),
      .data    (data_q),
      .rd_addr (mem_addr),
      .rd_data (cell_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_err <= 1'b0;
      else        row_err <= mem_ok && (mem_we || mem_re) && off_row;
   end

   assign mem_rdata = (mem_re && mem_ok && !off_row) ? cell_rd : '0;

   assign busy_w  = st.busy;
   assign stby_w  = st.stby;
   assign rmode_w = st.rmode;
   assign start_w = st.start;
   assign en_w    = st.en;
endmodule

// File: rtl/eerow_chk.sv
module eerow_chk #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 8,
   parameter int SEL_W       = 3,
   parameter int PROG_CYCLES = 16
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      busy,
   input logic                      stby,
   input logic                      rmode,
   input logic                      start,
   input logic                      en,
   input logic                      row_valid,
   input logic [ADDR_W-SEL_W-1:0]   row_q,
   input logic [ADDR_W-1:0]         mem_addr,
   input logic                      mem_we,
   input logic                      mem_re,
   input logic [DATA_W-1:0]         mem_rdata,
   input logic                      reg_we,
   input logic [7:0]                reg_wdata,
   input logic [7:0]                reg_rdata,
   input logic                      row_err
);
   localparam int RUN_W = $clog2(PROG_CYCLES + 1) + 1;
   logic [RUN_W-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_len == RUN_W'(PROG_CYCLES));

   p_busy_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> mem_rdata == '0);

   p_busy_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> reg_rdata == 8'h02);

   p_stby_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stby && !busy) |-> mem_rdata == '0);

   p_start_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !busy && !mem_we && reg_wdata[3] && !(en && rmode)) |=> !busy);

   p_end_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (!rmode && !start));

   p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[7] == 1'b0 && reg_rdata[5:4] == 2'b00);

   p_row_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rmode && row_valid && !busy && !stby && (mem_we || mem_re)
       && mem_addr[ADDR_W-1:SEL_W] != row_q) |=> row_err);
endmodule

bind eerow_ctrl eerow_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy_w),
   .stby      (stby_w),
   .rmode     (rmode_w),
   .start     (start_w),
   .en        (en_w),
   .row_valid (row_valid),
   .row_q     (row_q),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .mem_rdata (mem_rdata),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .row_err   (row_err)
);

// File: tb/sim_eerow_ctrl.sv
module sim_eerow_ctrl;
   localparam int PROG = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] mem_addr = '0;
   logic [7:0] mem_wdata = '0;
   logic       mem_we = 1'b0, mem_re = 1'b0, reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] mem_rdata, reg_rdata;
   logic       row_err;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [7:0] exp_mem [64];

   always #2 clk = ~clk;

   eerow_ctrl #(.PROG_CYCLES(PROG)) u0 (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .row_err(row_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [7:0] d);
      @(negedge clk); reg_we = 1'b1; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic mem_wr(input int a, input logic [7:0] d);
      @(negedge clk); mem_we = 1'b1; mem_addr = 6'(a); mem_wdata = d;
      @(negedge clk); mem_we = 1'b0;
   endtask

   task automatic mem_rd(input int a, output logic [7:0] v);
      @(negedge clk); mem_re = 1'b1; mem_addr = 6'(a);
      #1 v = mem_rdata;
      @(negedge clk); mem_re = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (reg_rdata[1] && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic sweep_page(input string req);
      for (int a = 0; a < 64; a++) begin
         logic [7:0] v;
         mem_rd(a, v);
         check(v == exp_mem[a], req, v, exp_mem[a]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog act=0 exp=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int n;
      for (int a = 0; a < 64; a++) exp_mem[a] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(reg_rdata == 8'h00, "R1 ctl reset", reg_rdata, 8'h00);
      sweep_page("R1 erased cells");

      // R2 field positions and reserved bits
      reg_wr(8'hB0);
      check(reg_rdata == 8'h00, "R2 reserved bits", reg_rdata, 8'h00);
      reg_wr(8'h01);
      check(reg_rdata == 8'h01, "R2 enable bit", reg_rdata, 8'h01);
      reg_wr(8'h41);
      check(reg_rdata == 8'h41, "R2 standby bit", reg_rdata, 8'h41);

      // R3 standby blocks access
      mem_wr(5, 8'h33);
      check(reg_rdata == 8'h41, "R3 no cycle in standby", reg_rdata, 8'h41);
      @(negedge clk); mem_re = 1'b1; mem_addr = 6'd7;
      #1 check(mem_rdata == 8'h00, "R3 standby read", mem_rdata, 8'h00);
      @(negedge clk); mem_re = 1'b0;
      reg_wr(8'h01);
      mem_rd(5, v);
      check(v == 8'hFF, "R3 write dropped", v, 8'hFF);

      // R4 enable low
      reg_wr(8'h00);
      mem_wr(9, 8'h12);
      check(reg_rdata == 8'h00, "R4 no cycle", reg_rdata, 8'h00);
      mem_rd(9, v);
      check(v == 8'hFF, "R4 cell unchanged", v, 8'hFF);

      // R5 byte mode over every address
      reg_wr(8'h01);
      for (int a = 0; a < 64; a++) begin
         logic [7:0] d;
         d = 8'((a * 37 + 11) & 255);
         mem_wr(a, d);
         check(reg_rdata == 8'h02, "R5 busy after write", reg_rdata, 8'h02);
         mem_re = 1'b1; mem_addr = 6'(a);
         #1 check(mem_rdata == 8'h00, "R5 read while busy", mem_rdata, 8'h00);
         mem_re = 1'b0;
         wait_idle(n);
         check(n == PROG, "R5 busy length", n, PROG);
         exp_mem[a] = d;
         mem_rd(a, v);
         check(v == d, "R5 byte stored", v, d);
      end
      sweep_page("R5 page after bytes");

      // R10 control writes ignored while busy
      mem_wr(20, 8'h5A);
      exp_mem[20] = 8'h5A;
      reg_we = 1'b1; reg_wdata = 8'h44;
      @(negedge clk); reg_we = 1'b0;
      wait_idle(n);
      check(n == PROG - 1, "R10 busy length", n, PROG - 1);
      check(reg_rdata == 8'h01, "R10 ctl frozen", reg_rdata, 8'h01);

      // R6 R8 R9 row mode per row
      for (int r = 0; r < 8; r++) begin
         logic [7:0] m;
         m = 8'(((r * 45) ^ 150) & 255) | 8'(1 << r);
         if (r == 0) m = 8'hFF;
         reg_wr(8'h05);
         check(reg_rdata == 8'h05, "R7 armed", reg_rdata, 8'h05);
         for (int j = 0; j < 8; j++) begin
            if (m[j]) begin
               int a;
               logic [7:0] d;
               a = r * 8 + j;
               d = 8'(((a * 91 + 7) ^ 60) & 255);
               mem_wr(a, d);
               exp_mem[a] = d;
            end
         end
         mem_wr(((r + 1) % 8) * 8 + 2, 8'hEE);
         check(row_err == 1'b1, "R6 off-row write flagged", row_err, 1);
         mem_rd(((r + 3) % 8) * 8 + 5, v);
         check(v == 8'h00, "R6 off-row read", v, 8'h00);
         check(row_err == 1'b1, "R6 off-row read flagged", row_err, 1);
         reg_wr(8'h0D);
         check(reg_rdata == 8'h02, "R7 start accepted", reg_rdata, 8'h02);
         wait_idle(n);
         check(n == PROG, "R7 row cycle length", n, PROG);
         check(reg_rdata == 8'h01, "R9 mode cleared at end", reg_rdata, 8'h01);
         sweep_page("R8 page after row commit");
      end

      // R7 start rejected without prior mode
      reg_wr(8'h0D);
      check(reg_rdata == 8'h05, "R7 start needs prior mode", reg_rdata, 8'h05);
      reg_wr(8'h0C);
      check(reg_rdata == 8'h04, "R7 start needs enable kept", reg_rdata, 8'h04);
      reg_wr(8'h0E);
      check(reg_rdata == 8'h04, "R7 start needs prior enable", reg_rdata, 8'h04);

      // R9 abandon discards collected bytes
      reg_wr(8'h00);
      reg_wr(8'h05);
      mem_wr(16, 8'hAB);
      reg_wr(8'h01);
      reg_wr(8'h05);
      reg_wr(8'h0D);
      wait_idle(n);
      check(n == PROG, "R9 empty cycle length", n, PROG);
      mem_rd(16, v);
      check(v == exp_mem[16], "R9 abandoned byte", v, exp_mem[16]);
      sweep_page("R9 page after abandon");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule